// File: doc/BRIEF.md
# Retrigger/Fault Input Conditioner

This block prepares one retrigger or fault input for a PWM waveform controller. It synchronizes two single-bit sources: a device pin and a comparator output that already arrives as a digital level. It picks one of them, applies a chosen active polarity and, if enabled, passes the result through a noise filter. The filter accepts a change only after four equal samples. From the conditioned signal it drives a level event, which is high while the signal is at its active level, and an edge event, which is a one-cycle pulse on each transition into the active level. When capture is enabled, it also drives a one-cycle capture strobe together with each edge event.

A single 8-bit control byte sets the block. The byte is loaded by a one-cycle write strobe. A 4-bit mode field in the byte is not interpreted here: it is held and passed to the downstream controller. A channel uses two instances, one for each retrigger/fault path, and each instance has its own control byte. The block has no data stream and no valid/ready interface. All pins are plain control or status signals, so back-pressure does not apply.

Top module: `retrig_cond`

## Requirements
- R1: After reset the control byte is 0. With both inputs low, `mode_out` is 0, `edge_evt` and `capture_stb` are 0, and `level_evt` is 1, because polarity 0 is active-low.
- R2: Control bit 6 picks the source: 0 takes `pin_in` and 1 takes `cmp_in`. Activity on the source that is not picked has no effect on any event output.
- R3: Control bit 5 sets the polarity. With 1, a rising edge or a high level is active. With 0, a falling edge or a low level is active. A transition in the other direction produces no edge event.
- R4: `level_evt` is high for as long as the conditioned signal sits at its active level.
- R5: With the filter off, `edge_evt` is a pulse exactly one cycle wide. It is high in the cycle after the second rising clock edge that follows an active input transition, because of the two-flop synchronizer.
- R6: With control bit 4 set (filter on), the conditioned signal changes only after four successive synchronized samples all show the new value. A pulse lasting three cycles produces no event.
- R7: With the filter on, the edge and level events appear exactly four cycles later than they do with the filter off.
- R8: With control bit 7 set, `capture_stb` is high in exactly the cycles in which `edge_evt` is high. With bit 7 clear, `capture_stb` stays 0.
- R9: A control write reloads the filter history and the edge-detect state from the newly selected input. Switching the source to an input at a different level therefore produces no edge event.
- R10: Control bits 3:0 appear unchanged on `mode_out` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte: [7] capture enable, [6] source select, [5] polarity, [4] filter enable, [3:0] mode |
| pin_in | input | 1 | Asynchronous external pin input |
| cmp_in | input | 1 | Asynchronous comparator output |
| level_evt | output | 1 | High while the conditioned input is at its active level |
| edge_evt | output | 1 | One-cycle pulse on an active transition |
| capture_stb | output | 1 | One-cycle capture strobe, qualified by capture enable |
| mode_out | output | 4 | Stored retrigger/fault mode field |

## Verification
The main function is tested with clean single transitions in both directions under both polarities. These tests separate edges into the active level from edges out of it, and they confirm the exact two-cycle synchronizer latency. A three-cycle glitch and a held step are applied with the filter on. The glitch separates a filter that needs four equal samples from one that needs fewer. The step pins the extra delay at exactly four cycles. Separate tests toggle the source that is not selected, switch the source when the two inputs sit at different levels, and toggle capture enable. These show that selection, reload-on-write and strobe gating each act independently.

// File: rtl/retrig_cond_pkg.sv
package retrig_cond_pkg;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned SYNC_N  = 2;
  localparam int unsigned FILT_N  = 4;
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned SEL_BIT = 6;

  typedef struct packed {
    logic              cap_en;
    logic              in_sel;
    logic              pol;
    logic              filt_en;
    logic [MODE_W-1:0] mode;
  } cfg_t;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rc_filter.sv
module rc_filter #(
  parameter int unsigned TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic din,
  output logic dout
);
  localparam int unsigned HW = TAPS - 1;

  logic [HW-1:0] hist;
  logic [TAPS-1:0] window;
  logic agree;

  assign window = {hist, din};
  assign agree  = (&window) | ~(|window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      dout <= 1'b0;
    end else if (load) begin
      hist <= {HW{load_val}};
      dout <= load_val;
    end else begin
      hist <= window[HW-1:0];
      if (agree) dout <= din;
    end
  end
endmodule

// File: rtl/rc_edge.sv
module rc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic cond,
  input  logic pol,
  output logic level,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev <= 1'b0;
    else if (load) prev <= load_val;
    else           prev <= cond;
  end

  assign level = pol ? cond : ~cond;
  assign pulse = pol ? (cond & ~prev) : (~cond & prev);
endmodule

// File: rtl/retrig_cond.sv
module retrig_cond
  import retrig_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              pin_in,
  input  logic              cmp_in,
  output logic              level_evt,
  output logic              edge_evt,
  output logic              capture_stb,
  output logic [MODE_W-1:0] mode_out
);
  cfg_t             cfg_q;
  logic [N_SRC-1:0] raw;
  logic [N_SRC-1:0] synced;
  logic             sel_now;
  logic             sel_load;
  logic             filt_q;
  logic             cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_t'(cfg_data);
  end

  assign raw = {cmp_in, pin_in};

  for (genvar g = 0; g < N_SRC; g++) begin : g_sync
    rc_sync #(.STAGES(SYNC_N)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw[g]),
      .q     (synced[g])
    );
  end

  assign sel_now  = synced[cfg_q.in_sel];
  assign sel_load = synced[cfg_data[SEL_BIT]];

  rc_filter #(.TAPS(FILT_N)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_wr),
    .load_val (sel_load),
    .din      (sel_now),
    .dout     (filt_q)
  );

  assign cond = cfg_q.filt_en ? filt_q : sel_now;

  rc_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_wr),
    .load_val (sel_load),
    .cond     (cond),
    .pol      (cfg_q.pol),
    .level    (level_evt),
    .pulse    (edge_evt)
  );

  assign capture_stb = edge_evt & cfg_q.cap_en;
  assign mode_out    = cfg_q.mode;
endmodule

// File: rtl/retrig_cond_chk.sv
module retrig_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [3:0] mode_in,
  input logic [3:0] mode_out,
  input logic       level_evt,
  input logic       edge_evt,
  input logic       capture_stb,
  input logic       cap_en
);
  p_edge_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !edge_evt);

  p_edge_implies_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |-> level_evt);

  p_cap_only_with_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_stb |-> (edge_evt && cap_en));

  p_cap_follows_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && cap_en) |-> capture_stb);

  p_mode_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mode_out == $past(mode_in)));
endmodule

bind retrig_cond retrig_cond_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .mode_in     (cfg_data[3:0]),
  .mode_out    (mode_out),
  .level_evt   (level_evt),
  .edge_evt    (edge_evt),
  .capture_stb (capture_stb),
  .cap_en      (cfg_q.cap_en)
);

// File: tb/retrig_cond_bench.sv
`timescale 1ns/1ps
module retrig_cond_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       pin_in = 1'b0;
  logic       cmp_in = 1'b0;
  logic       level_evt, edge_evt, capture_stb;
  logic [3:0] mode_out;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  retrig_cond u_retrig_cond (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .pin_in(pin_in), .cmp_in(cmp_in), .level_evt(level_evt),
    .edge_evt(edge_evt), .capture_stb(capture_stb), .mode_out(mode_out)
  );

  always @(posedge clk) if (rst_n && edge_evt) edge_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mode_out", mode_out, 0);
    chk("R1 edge_evt", edge_evt, 0);
    chk("R1 capture_stb", capture_stb, 0);
    chk("R1 level_evt", level_evt, 1);
  endtask

  task automatic t_rise_unfiltered;
    pin_in = 1'b0; step(4);
    write_cfg(8'h20);
    step(2);
    pin_in = 1'b1;
    step(1); chk("R5 no edge before sync", edge_evt, 0);
    step(1); chk("R5 edge after two flops", edge_evt, 1);
    chk("R4 level with edge", level_evt, 1);
    chk("R8 no strobe when disabled", capture_stb, 0);
    step(1); chk("R5 edge one cycle", edge_evt, 0);
    chk("R4 level held", level_evt, 1);
    step(3); chk("R4 level still held", level_evt, 1);
    begin
      int c0 = edge_cnt;
      pin_in = 1'b0;
      step(2); chk("R3 level drops", level_evt, 0);
      step(3); chk("R3 falling ignored at pol 1", edge_cnt - c0, 0);
    end
  endtask

  task automatic t_fall_capture;
    pin_in = 1'b1; step(4);
    write_cfg(8'h80);
    step(2);
    chk("R3 high inactive at pol 0", level_evt, 0);
    pin_in = 1'b0;
    step(2);
    chk("R3 falling edge active", edge_evt, 1);
    chk("R8 strobe with edge", capture_stb, 1);
    step(1);
    chk("R8 strobe one cycle", capture_stb, 0);
  endtask

  task automatic t_select;
    int c0;
    pin_in = 1'b0; cmp_in = 1'b0; step(4);
    write_cfg(8'h60);
    step(2);
    c0 = edge_cnt;
    pin_in = 1'b1; step(3); pin_in = 1'b0; step(3);
    chk("R2 unselected pin ignored", edge_cnt - c0, 0);
    chk("R2 level from comparator", level_evt, 0);
    cmp_in = 1'b1;
    step(2);
    chk("R2 comparator edge", edge_evt, 1);
    chk("R2 comparator level", level_evt, 1);
    cmp_in = 1'b0; step(4);
  endtask

  task automatic t_filter_glitch;
    int c0;
    pin_in = 1'b0; step(4);
    write_cfg(8'h30);
    step(2);
    c0 = edge_cnt;
    pin_in = 1'b1; step(3); pin_in = 1'b0;
    step(10);
    chk("R6 three-cycle glitch rejected", edge_cnt - c0, 0);
    chk("R6 level unchanged", level_evt, 0);
  endtask

  task automatic t_filter_delay;
    pin_in = 1'b0; step(4);
    write_cfg(8'h30);
    step(2);
    pin_in = 1'b1;
    step(5);
    chk("R7 no edge at unfiltered time plus 3", edge_evt, 0);
    chk("R7 level not yet", level_evt, 0);
    step(1);
    chk("R7 edge four cycles later", edge_evt, 1);
    chk("R7 level four cycles later", level_evt, 1);
    pin_in = 1'b0; step(8);
  endtask

  task automatic t_reload;
    int c0;
    pin_in = 1'b1; cmp_in = 1'b0; step(4);
    write_cfg(8'h00);
    step(3);
    c0 = edge_cnt;
    write_cfg(8'h40);
    step(5);
    chk("R9 no spurious edge on source switch", edge_cnt - c0, 0);
    chk("R9 level from new source", level_evt, 1);
    pin_in = 1'b0; step(4);
  endtask

  task automatic t_mode;
    write_cfg(8'h0B);
    chk("R10 mode 0xB", mode_out, 11);
    write_cfg(8'hF5);
    chk("R10 mode 0x5", mode_out, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_rise_unfiltered();
    t_fall_capture();
    t_select();
    t_filter_glitch();
    t_filter_delay();
    t_reload();
    t_mode();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule